// File: doc/BRIEF.md
# Interleaved I/Q Input Port Demultiplexer

This block takes one 12-bit input port that carries I-channel and Q-channel samples in alternation, one word per port-clock cycle. A tag line that comes with each word says which channel the word belongs to. The block samples word and tag together on the active port-clock edge, and it checks the tag against a polarity-swap control. The word then goes into an I holding register, or it is paired with the held I word as a Q sample. Each completed pair appears on two parallel outputs with a one-cycle valid strobe, so pairs come out at the per-channel rate, which is half the port-clock rate.

Configuration inputs set four things: the tag polarity, which port-clock edge captures the data, the interpolation factor code and the zero-stuff enable. The block turns the last two into an output-rate multiplier, which it reports. An interpolation factor of 1 is not allowed when the inputs are interleaved. That setting raises a configuration-error flag and blocks all pair output. A sticky flag records any break in the I/Q alternation.

Top module: `iq_port_demux`

## Requirements
- R1: With `sel_inv_i` = 0, a word captured with tag 0 is an I word and a word captured with tag 1 is a Q word.
- R2: With `sel_inv_i` = 1, the mapping is swapped: tag 1 marks an I word and tag 0 marks a Q word.
- R3: With `clk_inv_i` = 0, word and tag are sampled on the rising edge of `clk_i`. With `clk_inv_i` = 1, they are sampled on the preceding falling edge. In both cases a word held stable around its capture edge reaches the outputs after the second rising edge that follows its driving.
- R4: A Q word captured directly after an I word loads `i_o` with that I word and `q_o` with the Q word, both on the same edge, and raises `pair_valid_o` for exactly one cycle. In every other cycle `i_o` and `q_o` hold their values.
- R5: When two consecutive captured words carry the same channel, the later word replaces the earlier one and `seq_err_o` goes high. It stays high until reset.
- R6: `interp_i` code 0 (factor 1) sets `cfg_err_o` one rising edge later and keeps `pair_valid_o` low. Codes 1, 2 and 3 clear `cfg_err_o`.
- R7: `rate_mult_o` is combinational and equals 2^`interp_i` (codes 0..3 give 1, 2, 4, 8). It is doubled when `zstuff_i` = 1.
- R8: Reset clears `i_o`, `q_o`, `pair_valid_o`, `seq_err_o` and `cfg_err_o`. It also clears the channel history.
- R9: The first word captured after reset produces no pair and no sequence error, even when it is a Q word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Port clock at the interleaved word rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| word_i | input | 12 | Interleaved sample word |
| sel_i | input | 1 | Channel tag of the current word |
| sel_inv_i | input | 1 | Swap the tag-to-channel mapping |
| clk_inv_i | input | 1 | Capture on the falling port-clock edge |
| interp_i | input | 2 | Interpolation factor code, factor = 2^code |
| zstuff_i | input | 1 | Zero stuffing enable, doubles the multiplier |
| i_o | output | 12 | I sample of the last pair |
| q_o | output | 12 | Q sample of the last pair |
| pair_valid_o | output | 1 | One-cycle strobe for a new pair |
| seq_err_o | output | 1 | Sticky flag for a broken I/Q alternation |
| cfg_err_o | output | 1 | Interpolation factor 1 selected |
| rate_mult_o | output | 5 | Output sample rate multiplier |

## Verification
The assertions assume that the configuration inputs are quasi-static and change only around a reset. They also assume that the reset is applied at the start, before any clock edge. The bench sets every configuration value before it asserts reset and holds it for the whole scenario. In every cycle it drives one value before the falling edge and a different value after it. Only the capture edge that the configuration selects can then pick up the intended word.

// File: rtl/iq_demux_pkg.sv
`timescale 1ns/1ps
package iq_demux_pkg;

  typedef enum logic {
    CH_I = 1'b0,
    CH_Q = 1'b1
  } chan_e;

  function automatic chan_e map_tag(input logic tag, input logic inv);
    return chan_e'(tag ^ inv);
  endfunction

endpackage

// File: rtl/iq_edge_capture.sv
`timescale 1ns/1ps
module iq_edge_capture
  import iq_demux_pkg::*;
#(
  parameter int DATA_W  = 12,
  parameter bit FALL_EN = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clk_inv_i,
  input  logic              sel_inv_i,
  input  logic [DATA_W-1:0] word_i,
  input  logic              sel_i,
  output logic [DATA_W-1:0] cap_word_o,
  output chan_e             cap_ch_o,
  output logic              cap_vld_o
);

  logic [DATA_W-1:0] src_word;
  logic              src_sel;
  logic              src_vld;

  generate
    if (FALL_EN) begin : g_fall
      logic [DATA_W-1:0] neg_word_q;
      logic              neg_sel_q;
      logic              neg_vld_q;

      always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          neg_word_q <= '0;
          neg_sel_q  <= 1'b0;
          neg_vld_q  <= 1'b0;
        end else begin
          neg_word_q <= word_i;
          neg_sel_q  <= sel_i;
          neg_vld_q  <= 1'b1;
        end
      end

      // falling-edge sample is retimed so both modes share one latency
      always_comb begin
        if (clk_inv_i) begin
          src_word = neg_word_q;
          src_sel  = neg_sel_q;
          src_vld  = neg_vld_q;
        end else begin
          src_word = word_i;
          src_sel  = sel_i;
          src_vld  = 1'b1;
        end
      end
    end else begin : g_rise
      logic unused_inv;
      assign unused_inv = clk_inv_i;
      assign src_word   = word_i;
      assign src_sel    = sel_i;
      assign src_vld    = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_word_o <= '0;
      cap_ch_o   <= CH_I;
      cap_vld_o  <= 1'b0;
    end else begin
      cap_word_o <= src_word;
      cap_ch_o   <= map_tag(src_sel, sel_inv_i);
      cap_vld_o  <= src_vld;
    end
  end

endmodule

// File: rtl/iq_chan_steer.sv
`timescale 1ns/1ps
module iq_chan_steer
  import iq_demux_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] cap_word_i,
  input  chan_e             cap_ch_i,
  input  logic              cap_vld_i,
  input  logic              block_pair_i,
  output logic [DATA_W-1:0] i_o,
  output logic [DATA_W-1:0] q_o,
  output logic              pair_valid_o,
  output logic              seq_err_o
);

  logic [DATA_W-1:0] hold_i_q;
  logic              have_prev_q;
  chan_e             prev_ch_q;
  logic              repeat_ch;
  logic              close_pair;

  assign repeat_ch  = cap_vld_i && have_prev_q && (prev_ch_q == cap_ch_i);
  assign close_pair = cap_vld_i && have_prev_q && (prev_ch_q == CH_I)
                      && (cap_ch_i == CH_Q) && !block_pair_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_i_q    <= '0;
      have_prev_q <= 1'b0;
      prev_ch_q   <= CH_I;
    end else if (cap_vld_i) begin
      if (cap_ch_i == CH_I) hold_i_q <= cap_word_i;
      have_prev_q <= 1'b1;
      prev_ch_q   <= cap_ch_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      i_o          <= '0;
      q_o          <= '0;
      pair_valid_o <= 1'b0;
    end else begin
      pair_valid_o <= close_pair;
      if (close_pair) begin
        i_o <= hold_i_q;
        q_o <= cap_word_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        seq_err_o <= 1'b0;
    else if (repeat_ch) seq_err_o <= 1'b1;
  end

endmodule

// File: rtl/iq_rate_cfg.sv
`timescale 1ns/1ps
module iq_rate_cfg #(
  parameter int INTERP_W = 2,
  parameter int MULT_W   = (1 << INTERP_W) + 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [INTERP_W-1:0] interp_i,
  input  logic                zstuff_i,
  output logic [MULT_W-1:0]   rate_mult_o,
  output logic                cfg_bad_o,
  output logic                cfg_err_o
);

  logic [MULT_W-1:0] base_mult;

  assign base_mult   = MULT_W'(1) << interp_i;
  assign rate_mult_o = zstuff_i ? (base_mult << 1) : base_mult;
  // factor 1 cannot carry two interleaved channels
  assign cfg_bad_o   = (interp_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_err_o <= 1'b0;
    else         cfg_err_o <= cfg_bad_o;
  end

endmodule

// File: rtl/iq_port_demux.sv
`timescale 1ns/1ps
module iq_port_demux
  import iq_demux_pkg::*;
#(
  parameter int DATA_W   = 12,
  parameter int INTERP_W = 2,
  parameter bit FALL_EN  = 1'b1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [DATA_W-1:0]     word_i,
  input  logic                  sel_i,
  input  logic                  sel_inv_i,
  input  logic                  clk_inv_i,
  input  logic [INTERP_W-1:0]   interp_i,
  input  logic                  zstuff_i,
  output logic [DATA_W-1:0]     i_o,
  output logic [DATA_W-1:0]     q_o,
  output logic                  pair_valid_o,
  output logic                  seq_err_o,
  output logic                  cfg_err_o,
  output logic [(1<<INTERP_W):0] rate_mult_o
);

  localparam int MULT_W = (1 << INTERP_W) + 1;

  logic [DATA_W-1:0] cap_word;
  chan_e             cap_ch;
  logic              cap_vld;
  logic              cfg_bad;

  iq_edge_capture #(
    .DATA_W  (DATA_W),
    .FALL_EN (FALL_EN)
  ) capture_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clk_inv_i  (clk_inv_i),
    .sel_inv_i  (sel_inv_i),
    .word_i     (word_i),
    .sel_i      (sel_i),
    .cap_word_o (cap_word),
    .cap_ch_o   (cap_ch),
    .cap_vld_o  (cap_vld)
  );

  iq_rate_cfg #(
    .INTERP_W (INTERP_W),
    .MULT_W   (MULT_W)
  ) rate_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .interp_i    (interp_i),
    .zstuff_i    (zstuff_i),
    .rate_mult_o (rate_mult_o),
    .cfg_bad_o   (cfg_bad),
    .cfg_err_o   (cfg_err_o)
  );

  iq_chan_steer #(
    .DATA_W (DATA_W)
  ) steer_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cap_word_i   (cap_word),
    .cap_ch_i     (cap_ch),
    .cap_vld_i    (cap_vld),
    .block_pair_i (cfg_bad),
    .i_o          (i_o),
    .q_o          (q_o),
    .pair_valid_o (pair_valid_o),
    .seq_err_o    (seq_err_o)
  );

endmodule

// File: rtl/iq_port_demux_chk.sv
`timescale 1ns/1ps
module iq_port_demux_chk #(
  parameter int DATA_W   = 12,
  parameter int INTERP_W = 2
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [INTERP_W-1:0]    interp_i,
  input logic                   zstuff_i,
  input logic [DATA_W-1:0]      i_o,
  input logic [DATA_W-1:0]      q_o,
  input logic                   pair_valid_o,
  input logic                   seq_err_o,
  input logic                   cfg_err_o,
  input logic [(1<<INTERP_W):0] rate_mult_o
);

  assert_pair_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pair_valid_o |=> !pair_valid_o);

  assert_pair_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pair_valid_o |-> ($stable(i_o) && $stable(q_o)));

  assert_seq_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_err_o |=> seq_err_o);

  assert_cfg_flag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (interp_i == '0) |=> cfg_err_o);

  assert_cfg_block_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> !pair_valid_o);

  assert_rate_pow2_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(rate_mult_o) == 1);

  assert_rate_zstuff_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zstuff_i |-> !rate_mult_o[0]);

  assert_reset_clear_R8: assert property (@(posedge clk_i)
    !rst_ni |-> (!pair_valid_o && !seq_err_o && !cfg_err_o && i_o == '0 && q_o == '0));

endmodule

bind iq_port_demux iq_port_demux_chk #(
  .DATA_W   (DATA_W),
  .INTERP_W (INTERP_W)
) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .interp_i     (interp_i),
  .zstuff_i     (zstuff_i),
  .i_o          (i_o),
  .q_o          (q_o),
  .pair_valid_o (pair_valid_o),
  .seq_err_o    (seq_err_o),
  .cfg_err_o    (cfg_err_o),
  .rate_mult_o  (rate_mult_o)
);

// File: tb/iq_port_demux_tb_top.sv
`timescale 1ns/1ps
module iq_port_demux_tb_top;

  localparam int DW = 12;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [DW-1:0] word_i = '0;
  logic          sel_i = 1'b0;
  logic          sel_inv = 1'b0;
  logic          clk_inv = 1'b0;
  logic [1:0]    interp = 2'd1;
  logic          zstuff = 1'b0;
  logic [DW-1:0] i_o, q_o;
  logic          pair_valid_o, seq_err_o, cfg_err_o;
  logic [4:0]    rate_mult_o;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  iq_port_demux dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .word_i       (word_i),
    .sel_i        (sel_i),
    .sel_inv_i    (sel_inv),
    .clk_inv_i    (clk_inv),
    .interp_i     (interp),
    .zstuff_i     (zstuff),
    .i_o          (i_o),
    .q_o          (q_o),
    .pair_valid_o (pair_valid_o),
    .seq_err_o    (seq_err_o),
    .cfg_err_o    (cfg_err_o),
    .rate_mult_o  (rate_mult_o)
  );

  // expected state, derived from the requirements
  logic [DW-1:0] hist_w [0:255];
  logic          hist_s [0:255];
  int            n;
  logic          m_have, m_prev_q, m_v, m_seq;
  logic [DW-1:0] m_hold, m_i, m_q;

  task automatic check(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic model_word(input int k);
    logic is_q;
    is_q = hist_s[k] ^ sel_inv;
    m_v  = 1'b0;
    if (m_have && (m_prev_q == is_q)) m_seq = 1'b1;
    if (!is_q) m_hold = hist_w[k];
    else if (m_have && !m_prev_q && interp != 2'd0) begin
      m_i = m_hold;
      m_q = hist_w[k];
      m_v = 1'b1;
    end
    m_have   = 1'b1;
    m_prev_q = is_q;
  endtask

  task automatic apply_reset();
    rst_ni = 1'b0;
    word_i = '0;
    sel_i  = 1'b0;
    repeat (2) @(posedge clk);
    #12;
    check("R8 reset pair_valid", pair_valid_o, 0);
    check("R8 reset i_o", i_o, 0);
    check("R8 reset q_o", q_o, 0);
    check("R8 reset seq_err", seq_err_o, 0);
    check("R8 reset cfg_err", cfg_err_o, 0);
    m_have = 0; m_prev_q = 0; m_v = 0; m_seq = 0;
    m_hold = '0; m_i = '0; m_q = '0;
    n = 0;
  endtask

  // one word per cycle; the other half-cycle carries a decoy
  task automatic step(input logic [DW-1:0] w, input logic s, input string tag);
    @(posedge clk);
    #5;
    if (n == 0) rst_ni = 1'b1;
    word_i = clk_inv ? w : ~w;
    sel_i  = clk_inv ? s : ~s;
    hist_w[n] = w;
    hist_s[n] = s;
    #7;
    if (n >= 2) model_word(n - 2);
    else m_v = 1'b0;
    check({tag, " pair_valid"}, pair_valid_o, m_v);
    check({tag, " i_o"}, i_o, m_i);
    check({tag, " q_o"}, q_o, m_q);
    check("R5 seq_err", seq_err_o, m_seq);
    check("R6 cfg_err", cfg_err_o, (n >= 1 && interp == 2'd0) ? 1 : 0);
    #1;
    word_i = clk_inv ? ~w : w;
    sel_i  = clk_inv ? ~s : s;
    n++;
  endtask

  task automatic flush(input string tag);
    step(12'h0F0, 1'b0 ^ sel_inv, tag);
    step(12'h00F, 1'b1 ^ sel_inv, tag);
    step(12'h0F0, 1'b0 ^ sel_inv, tag);
  endtask

  task automatic t_normal();
    sel_inv = 0; clk_inv = 0; interp = 2'd2; zstuff = 0;
    apply_reset();
    step(12'h5A5, 1'b1, "R9 lone Q");
    step(12'h123, 1'b0, "R1");
    step(12'hABC, 1'b1, "R4");
    step(12'h000, 1'b0, "R1");
    step(12'hFFF, 1'b1, "R4");
    step(12'h800, 1'b0, "R1");
    step(12'h001, 1'b1, "R4");
    flush("R4");
  endtask

  task automatic t_swap();
    sel_inv = 1; clk_inv = 0; interp = 2'd1; zstuff = 0;
    apply_reset();
    step(12'h321, 1'b1, "R2");
    step(12'h654, 1'b0, "R2");
    step(12'h987, 1'b1, "R2");
    step(12'hCBA, 1'b0, "R2");
    flush("R2");
  endtask

  task automatic t_fall();
    sel_inv = 0; clk_inv = 1; interp = 2'd3; zstuff = 1;
    apply_reset();
    step(12'h111, 1'b0, "R3");
    step(12'h222, 1'b1, "R3");
    step(12'h7FE, 1'b0, "R3");
    step(12'h801, 1'b1, "R3");
    flush("R3");
    sel_inv = 1;
    apply_reset();
    step(12'h3C3, 1'b1, "R3 swapped");
    step(12'hC3C, 1'b0, "R3 swapped");
    flush("R3 swapped");
  endtask

  task automatic t_seq_err();
    sel_inv = 0; clk_inv = 0; interp = 2'd1; zstuff = 0;
    apply_reset();
    step(12'h100, 1'b0, "R5");
    step(12'h200, 1'b0, "R5 repeat I");
    step(12'h300, 1'b1, "R5");
    step(12'h400, 1'b1, "R5 repeat Q");
    step(12'h500, 1'b0, "R5");
    step(12'h600, 1'b1, "R5");
    flush("R5");
    check("R5 sticky after good pairs", seq_err_o, 1);
    apply_reset();
    step(12'h0AA, 1'b0, "R8 after reset");
    step(12'h0BB, 1'b1, "R8 after reset");
    flush("R8");
  endtask

  task automatic t_cfg();
    sel_inv = 0; clk_inv = 0; interp = 2'd0; zstuff = 0;
    apply_reset();
    step(12'h010, 1'b0, "R6");
    step(12'h020, 1'b1, "R6");
    step(12'h030, 1'b0, "R6");
    step(12'h040, 1'b1, "R6");
    flush("R6");
  endtask

  task automatic t_rate();
    for (int c = 0; c < 4; c++) begin
      for (int z = 0; z < 2; z++) begin
        interp = 2'(c);
        zstuff = 1'(z);
        #1;
        check($sformatf("R7 rate code %0d zs %0d", c, z), rate_mult_o, (1 << c) * (z + 1));
      end
    end
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_normal();
    t_swap();
    t_fall();
    t_seq_err();
    t_cfg();
    t_rate();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule